// File: doc/BRIEF.md
# Pooled Device Hot-Plug Sequencer

This block moves devices in a shared pool between hosts without any physical detach. A host holding a device can ask to give it back. The sequencer asks that host to quiesce traffic and waits for a safe-to-remove acknowledgement. When the acknowledgement arrives, it clears the device's binding and returns the device to the free pool. A host that needs more resources asks for an allocation. The sequencer binds the lowest-numbered free device to that host, keeps traffic disabled and runs a hot-add handshake with the host. Traffic to the device is enabled only after the host reports the hot-add complete.

The block services one request at a time. When several hosts ask together, the lowest host index goes first and the others keep their requests raised until their turn. An allocation with no free device is answered with a failure. A release of a device the host does not own is also answered with a failure and leaves all state as it was. A quiesce that receives no acknowledgement within a programmable number of cycles is abandoned, and the device stays bound to its host with traffic still enabled.

Top module: `pool_hotplug_seq`

## Requirements
- R1: After reset no device is bound, every traffic enable is low, and no quiesce request, add request or response is raised.
- R2: An allocation request (request kind 0) binds the lowest-index free device to the requester with traffic off. It then raises that host's add request with `hp_dev` equal to the device. Ownership is read per device d as `own_valid[d]` and `own_host[d*HOST_W +: HOST_W]`.
- R3: A device's traffic enable rises only after `add_done` from the host being added. An `add_done` from any other host has no effect. The requester then gets a one-cycle response with `resp_ok`=1 and `resp_dev` equal to the device.
- R4: An allocation request when every device is bound gets a response with `resp_ok`=0 and changes no binding.
- R5: A release request (request kind 1, device taken from `req_dev[h*DEV_W +: DEV_W]`) from the owning host raises that host's quiesce request with `hp_dev` equal to the device. The binding and traffic enable stay unchanged until the acknowledgement arrives.
- R6: A `safe_ack` from the owner during quiesce unbinds the device and turns off its traffic. The owner gets a response with `resp_ok`=1, and the device becomes available to any host.
- R7: A release request for a device that is unbound or bound to another host gets `resp_ok`=0, raises no quiesce request and changes no state.
- R8: If no `safe_ack` arrives, the quiesce request stays high for exactly `quiesce_limit`+1 cycles. The host then gets `resp_ok`=0, and the device keeps its binding and traffic.
- R9: Only one handshake runs at a time, and requests raised together are served in increasing host index order.
- R10: A device's traffic enable is never high while the device is unbound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| quiesce_limit | input | TMR_W | Cycles to wait for a safe-to-remove acknowledgement |
| req_valid | input | N_HOST | Per-host request, held until its response |
| req_kind | input | N_HOST | Per-host request kind: 0 allocate, 1 release |
| req_dev | input | N_HOST*DEV_W | Per-host device number for a release |
| resp_valid | output | N_HOST | One-cycle response strobe to the served host |
| resp_ok | output | 1 | Response outcome |
| resp_dev | output | DEV_W | Device concerned by the response |
| quiesce_req | output | N_HOST | Asks the host to stop traffic to `hp_dev` |
| safe_ack | input | N_HOST | Host reports removal is safe |
| add_req | output | N_HOST | Asks the host to hot-add `hp_dev` |
| add_done | input | N_HOST | Host reports hot-add complete |
| hp_dev | output | DEV_W | Device of the running handshake |
| own_valid | output | N_DEV | Per-device bound flag |
| own_host | output | N_DEV*HOST_W | Per-device owning host index |
| traffic_en | output | N_DEV | Per-device traffic enable |

## Verification
The bench fills the whole pool through every host and checks the exhaustion failure. It tries a release from the wrong host on every device. It runs a timed-out quiesce and counts its exact length, so an off-by-one timer or a timeout that drops the binding is reported. During a hot-add it pulses `add_done` from a foreign host, which catches a design that enables traffic on the wrong acknowledgement. Freed devices are reallocated to check lowest-index reuse. Two simultaneous allocations check that a design serving both at once, or in the wrong order, is caught.

// File: rtl/hpseq_pkg.sv
// Shared types of the pooled device hot-plug sequencer.
package hpseq_pkg;
    typedef enum logic [1:0] {S_IDLE, S_QUIESCE, S_ADD, S_RESP} seq_state_t;
    typedef enum logic {OP_ALLOC = 1'b0, OP_RELEASE = 1'b1} op_kind_t;
endpackage

// File: rtl/hpseq_arbiter.sv
// Fixed-priority picker: reports whether any bit of req is set and the
// index of the lowest set bit. Purely combinational; no state assumed.
module hpseq_arbiter #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set index is the last one written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/hpseq_own_table.sv
// Per-device ownership and traffic-enable registers. A bind sets the valid
// bit and host field with traffic off; an unbind clears valid and traffic;
// an enable turns traffic on. The controller issues at most one per cycle.
module hpseq_own_table #(
    parameter int N_DEV  = 8,
    parameter int N_HOST = 4,
    localparam int DEV_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int HOST_W = (N_HOST > 1) ? $clog2(N_HOST) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bind_en,
    input  logic [DEV_W-1:0]        bind_dev,
    input  logic [HOST_W-1:0]       bind_host,
    input  logic                    unbind_en,
    input  logic [DEV_W-1:0]        unbind_dev,
    input  logic                    enable_en,
    input  logic [DEV_W-1:0]        enable_dev,
    output logic [N_DEV-1:0]        own_valid,
    output logic [N_DEV*HOST_W-1:0] own_host,
    output logic [N_DEV-1:0]        traffic_en
);
    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
        // Update one device entry from the controller's commands.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                own_valid[d]                     <= 1'b0;
                own_host[d*HOST_W +: HOST_W]     <= '0;
                traffic_en[d]                    <= 1'b0;
            end else if (bind_en && bind_dev == DEV_W'(d)) begin
                own_valid[d]                     <= 1'b1;
                own_host[d*HOST_W +: HOST_W]     <= bind_host;
                traffic_en[d]                    <= 1'b0;
            end else if (unbind_en && unbind_dev == DEV_W'(d)) begin
                own_valid[d]                     <= 1'b0;
                traffic_en[d]                    <= 1'b0;
            end else if (enable_en && enable_dev == DEV_W'(d)) begin
                traffic_en[d]                    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/hpseq_timer.sv
// Quiesce timeout counter: cleared while idle, counts while running, and
// reports expiry once the count reaches the limit. Limit is held stable
// during a quiesce.
module hpseq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = (cnt >= limit);

    // Count wait cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (run && !expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pool_hotplug_seq.sv
// Pooled device hot-plug sequencer. Serves one host request at a time,
// lowest host index first. Allocation binds the lowest free device and runs
// a hot-add handshake before enabling traffic; release checks ownership,
// runs a quiesce handshake with a timeout, then unbinds. Assumes hosts hold
// req_valid until their response strobe and drop it in that cycle.
module pool_hotplug_seq
    import hpseq_pkg::*;
#(
    parameter int N_DEV  = 8,
    parameter int N_HOST = 4,
    parameter int TMR_W  = 16,
    localparam int DEV_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int HOST_W = (N_HOST > 1) ? $clog2(N_HOST) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TMR_W-1:0]        quiesce_limit,
    input  logic [N_HOST-1:0]       req_valid,
    input  logic [N_HOST-1:0]       req_kind,
    input  logic [N_HOST*DEV_W-1:0] req_dev,
    output logic [N_HOST-1:0]       resp_valid,
    output logic                    resp_ok,
    output logic [DEV_W-1:0]        resp_dev,
    output logic [N_HOST-1:0]       quiesce_req,
    input  logic [N_HOST-1:0]       safe_ack,
    output logic [N_HOST-1:0]       add_req,
    input  logic [N_HOST-1:0]       add_done,
    output logic [DEV_W-1:0]        hp_dev,
    output logic [N_DEV-1:0]        own_valid,
    output logic [N_DEV*HOST_W-1:0] own_host,
    output logic [N_DEV-1:0]        traffic_en
);
    seq_state_t          state;
    logic [HOST_W-1:0]   cur_host;
    logic [DEV_W-1:0]    cur_dev;
    logic                cur_ok;

    logic                host_any;
    logic [HOST_W-1:0]   host_sel;
    logic                free_any;
    logic [DEV_W-1:0]    free_sel;
    logic [DEV_W-1:0]    rel_dev;
    op_kind_t            sel_kind;
    logic                owner_match;
    logic                tmo;

    logic                bind_en, unbind_en, enable_en;

    hpseq_arbiter #(.N(N_HOST)) u_host_arb (
        .req(req_valid), .any(host_any), .idx(host_sel)
    );

    hpseq_arbiter #(.N(N_DEV)) u_free_pick (
        .req(~own_valid), .any(free_any), .idx(free_sel)
    );

    hpseq_own_table #(.N_DEV(N_DEV), .N_HOST(N_HOST)) u_table (
        .clk(clk), .rst_n(rst_n),
        .bind_en(bind_en), .bind_dev(free_sel), .bind_host(host_sel),
        .unbind_en(unbind_en), .unbind_dev(cur_dev),
        .enable_en(enable_en), .enable_dev(cur_dev),
        .own_valid(own_valid), .own_host(own_host), .traffic_en(traffic_en)
    );

    hpseq_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clear(state != S_QUIESCE), .run(state == S_QUIESCE),
        .limit(quiesce_limit), .expired(tmo)
    );

    // Decode the granted host's request and its ownership check.
    always_comb begin
        sel_kind    = op_kind_t'(req_kind[host_sel]);
        rel_dev     = req_dev[host_sel*DEV_W +: DEV_W];
        owner_match = own_valid[rel_dev] &&
                      (own_host[rel_dev*HOST_W +: HOST_W] == host_sel);
    end

    // Table commands issued by the sequencer.
    always_comb begin
        bind_en   = (state == S_IDLE) && host_any && (sel_kind == OP_ALLOC) && free_any;
        unbind_en = (state == S_QUIESCE) && safe_ack[cur_host];
        enable_en = (state == S_ADD) && add_done[cur_host];
    end

    // Sequencer state, served host, device and outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_host <= '0;
            cur_dev  <= '0;
            cur_ok   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (host_any) begin
                    cur_host <= host_sel;
                    if (sel_kind == OP_ALLOC) begin
                        cur_dev <= free_any ? free_sel : '0;
                        cur_ok  <= 1'b0;
                        state   <= free_any ? S_ADD : S_RESP;
                    end else begin
                        cur_dev <= rel_dev;
                        cur_ok  <= 1'b0;
                        state   <= owner_match ? S_QUIESCE : S_RESP;
                    end
                end
                S_QUIESCE: if (safe_ack[cur_host]) begin
                    cur_ok <= 1'b1;
                    state  <= S_RESP;
                end else if (tmo) begin
                    cur_ok <= 1'b0;
                    state  <= S_RESP;
                end
                S_ADD: if (add_done[cur_host]) begin
                    cur_ok <= 1'b1;
                    state  <= S_RESP;
                end
                S_RESP: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Per-host handshake strobes follow the state and served host.
    always_comb begin
        quiesce_req = (state == S_QUIESCE) ? (N_HOST'(1) << cur_host) : '0;
        add_req     = (state == S_ADD)     ? (N_HOST'(1) << cur_host) : '0;
        resp_valid  = (state == S_RESP)    ? (N_HOST'(1) << cur_host) : '0;
        resp_ok     = cur_ok;
        resp_dev    = cur_dev;
        hp_dev      = cur_dev;
    end
endmodule

// File: rtl/hpseq_checker.sv
// Protocol checker for pool_hotplug_seq, bound to every instance.
module hpseq_checker #(
    parameter int N_DEV  = 8,
    parameter int N_HOST = 4,
    parameter int TMR_W  = 16,
    parameter int DEV_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TMR_W-1:0]  quiesce_limit,
    input logic [N_HOST-1:0] quiesce_req,
    input logic [N_HOST-1:0] add_req,
    input logic [N_HOST-1:0] resp_valid,
    input logic [DEV_W-1:0]  hp_dev,
    input logic [N_DEV-1:0]  own_valid,
    input logic [N_DEV-1:0]  traffic_en
);
    logic [TMR_W:0] q_run;

    // Count consecutive cycles with a quiesce request raised.
    always_ff @(posedge clk) begin
        if (!rst_n) q_run <= '0;
        else if (|quiesce_req) q_run <= q_run + 1'b1;
        else q_run <= '0;
    end

    p_one_handshake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({quiesce_req, add_req, resp_valid}));

    p_quiesce_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|quiesce_req) |-> (q_run <= {1'b0, quiesce_limit}));

    p_quiesce_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|quiesce_req) |-> (own_valid[hp_dev] && traffic_en[hp_dev]));

    for (genvar d = 0; d < N_DEV; d++) begin : g_chk
        p_traffic_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
            traffic_en[d] |-> own_valid[d]);
        p_bind_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(own_valid[d]) |-> !traffic_en[d]);
        p_enable_after_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(traffic_en[d]) |-> $past(|add_req));
    end
endmodule

bind pool_hotplug_seq hpseq_checker #(
    .N_DEV(N_DEV), .N_HOST(N_HOST), .TMR_W(TMR_W), .DEV_W(DEV_W)
) u_chk (.*);

// File: tb/sim_pool_hotplug_seq.sv
module sim_pool_hotplug_seq;
    localparam int ND = 8, NH = 4, DW = 3, HW = 2, TW = 16, QLIM = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [TW-1:0] quiesce_limit = TW'(QLIM);
    logic [NH-1:0] req_valid = '0, req_kind = '0, safe_ack = '0, add_done = '0;
    logic [NH*DW-1:0] req_dev = '0;
    logic [NH-1:0] resp_valid, quiesce_req, add_req;
    logic resp_ok;
    logic [DW-1:0] resp_dev, hp_dev;
    logic [ND-1:0] own_valid, traffic_en;
    logic [ND*HW-1:0] own_host;

    int nchk = 0, nerr = 0;
    bit done = 0;
    bit exp_v[ND];
    int exp_h[ND];
    bit exp_t[ND];

    always #5 clk = ~clk;

    pool_hotplug_seq u0 (.*);

    task automatic tick(); @(negedge clk); endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_table(string tag);
        bit ok = 1;
        int bad = 0;
        for (int d = 0; d < ND; d++) begin
            if (own_valid[d] != exp_v[d] || traffic_en[d] != exp_t[d] ||
                (exp_v[d] && int'(own_host[d*HW +: HW]) != exp_h[d])) begin
                if (ok) bad = d;
                ok = 0;
            end
        end
        chk(ok, {tag, " table"}, int'({own_valid[bad], traffic_en[bad], own_host[bad*HW +: HW]}),
            (int'(exp_v[bad]) << 3) | (int'(exp_t[bad]) << 2) | exp_h[bad]);
        chk((traffic_en & ~own_valid) == '0, "R10 traffic on unbound", int'(traffic_en), int'(own_valid));
    endtask

    task automatic set_req(int h, bit kind, int d);
        req_valid[h] = 1'b1;
        req_kind[h] = kind;
        req_dev[h*DW +: DW] = DW'(d);
    endtask

    task automatic finish_alloc(int h, int d);
        int o = (h + 1) % NH;
        for (int i = 0; i < 40 && !add_req[h] && !resp_valid[h]; i++) tick();
        chk(add_req[h] == 1'b1, "R2 add_req", int'(add_req), 1 << h);
        chk(int'(hp_dev) == d, "R2 hp_dev lowest free", int'(hp_dev), d);
        exp_v[d] = 1; exp_h[d] = h; exp_t[d] = 0;
        check_table("R2");
        add_done[o] = 1'b1; tick(); tick(); add_done[o] = 1'b0;
        chk(traffic_en[d] == 1'b0, "R3 foreign add_done", int'(traffic_en[d]), 0);
        add_done[h] = 1'b1; tick(); add_done[h] = 1'b0;
        chk(resp_valid[h] && resp_ok, "R3 resp ok", int'({resp_valid, resp_ok}), 1);
        chk(int'(resp_dev) == d, "R3 resp_dev", int'(resp_dev), d);
        exp_t[d] = 1;
        check_table("R3");
        req_valid[h] = 1'b0; tick();
    endtask

    task automatic alloc_fail(int h);
        set_req(h, 1'b0, 0); tick();
        for (int i = 0; i < 40 && !resp_valid[h]; i++) tick();
        chk(resp_valid[h] && !resp_ok, "R4 exhausted fail", int'(resp_ok), 0);
        check_table("R4");
        req_valid[h] = 1'b0; tick();
    endtask

    // mode 0: expect reject; 1: ack after delay; 2: never ack (timeout)
    task automatic remove(int h, int d, int mode, int dly);
        int n = 0;
        bit qseen = 0;
        set_req(h, 1'b1, d); tick();
        if (mode == 0) begin
            for (int i = 0; i < 40 && !resp_valid[h]; i++) begin
                if (quiesce_req != '0) qseen = 1;
                tick();
            end
            chk(resp_valid[h] && !resp_ok && !qseen, "R7 reject", int'({qseen, resp_ok}), 0);
            check_table("R7");
        end else if (mode == 1) begin
            for (int i = 0; i < 40 && !quiesce_req[h]; i++) tick();
            chk(quiesce_req[h] && int'(hp_dev) == d, "R5 quiesce", int'(hp_dev), d);
            repeat (dly) tick();
            check_table("R5");
            safe_ack[h] = 1'b1; tick(); safe_ack[h] = 1'b0;
            chk(resp_valid[h] && resp_ok, "R6 release ok", int'(resp_ok), 1);
            exp_v[d] = 0; exp_t[d] = 0;
            check_table("R6");
        end else begin
            while (quiesce_req[h] && n < 40) begin n++; tick(); end
            chk(n == QLIM + 1, "R8 quiesce length", n, QLIM + 1);
            chk(resp_valid[h] && !resp_ok, "R8 timeout fail", int'(resp_ok), 0);
            check_table("R8");
        end
        req_valid[h] = 1'b0; tick();
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        for (int d = 0; d < ND; d++) begin exp_v[d] = 0; exp_h[d] = 0; exp_t[d] = 0; end
        repeat (3) tick();
        rst_n = 1'b1; tick();
        chk(own_valid == '0 && traffic_en == '0, "R1 table", int'({own_valid, traffic_en}), 0);
        chk(quiesce_req == '0 && add_req == '0 && resp_valid == '0, "R1 strobes",
            int'({quiesce_req, add_req, resp_valid}), 0);
        // fill the pool from rotating hosts
        for (int k = 0; k < ND; k++) begin
            set_req(k % NH, 1'b0, 0); tick();
            finish_alloc(k % NH, k);
        end
        alloc_fail(1);
        // wrong-owner releases on every device
        for (int d = 0; d < ND; d++) remove((d % NH + 1) % NH, d, 0, 0);
        remove(2, 2, 2, 0);
        remove(1, 5, 1, 2);
        remove(2, 2, 1, 0);
        remove(0, 5, 0, 0);
        // reuse: lowest free is device 2
        set_req(3, 1'b0, 0); tick();
        finish_alloc(3, 2);
        remove(3, 7, 1, 1);
        // simultaneous allocations from hosts 2 and 0 (R9)
        set_req(2, 1'b0, 0); set_req(0, 1'b0, 0); tick();
        chk(add_req == 4'b0001, "R9 lowest host first", int'(add_req), 1);
        finish_alloc(0, 5);
        chk(add_req[2] == 1'b0, "R9 second waits", int'(add_req), 0);
        finish_alloc(2, 7);
        done = 1;
        report();
    end
endmodule